// File: doc/BRIEF.md
# PLL Configuration Register Bank

This block holds the configuration of one PLL behind a simple single-cycle register bus. It has four 32-bit words. Software programs the feedback divider, the reference divider, two output post-dividers, a 24-bit fractional value, a power-down control and an integer/fractional mode select. The stored fields drive the PLL directly through dedicated output ports.

Three of the words take bit-masked writes. The upper half of the written word acts as a per-bit write enable for the lower half, so one field can change without a read-modify-write sequence. The fractional word is written as a plain full word. A read of that word also returns the PLL lock indication in its top bit, after a synchronizer.

Reads are combinational from the address. Bits that hold no field read as zero.

Top module: `pllcfg_regs`

## Requirements
- R1: After reset the outputs are: feedback divider 1, reference divider 1, both post-dividers 1, fraction 0, power-down 1 and integer mode 1. Word 0 reads 0x00000001, word 1 reads 0x00001101, word 2 reads 0x00000000 while the lock input is low, and word 3 reads 0x00000009.
- R2: In words 0, 1 and 3, bit i (0..15) of the stored value takes bit i of the write data only when bit i+16 of the write data is 1. Otherwise it keeps its value. Without a write, every stored bit keeps its value.
- R3: Word 0 holds the 12-bit feedback divider in bits [11:0]. Bits [31:12] read 0 and cannot be set.
- R4: Word 1 holds the 6-bit reference divider in [5:0], post-divider 1 in [10:8] and post-divider 2 in [14:12]. All other bits read 0 and cannot be set.
- R5: A write to word 2 loads bits [23:0] of the write data into the fraction in full, with no mask. Bits [30:24] read 0. A write to any other word leaves the fraction unchanged.
- R6: Bit 31 of word 2 reads the lock input delayed by two clock edges through a synchronizer, and so does the lock output. Writes to bit 31 have no effect.
- R7: Word 3 holds power-down in bit 0 (1 = powered down) and integer mode in bit 3 (1 = integer). All other bits read 0 and cannot be set.
- R8: The word is selected by address bits [3:2], so word offsets are 0x0, 0x4, 0x8 and 0xC. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 4 | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data; the high half is the bit mask for masked words |
| bus_rdata | output | 32 | Read data of the addressed word |
| pll_lock_in | input | 1 | Asynchronous lock indication from the PLL |
| fb_div | output | 12 | Feedback divider |
| ref_div | output | 6 | Reference divider |
| post_div1 | output | 3 | First post-divider |
| post_div2 | output | 3 | Second post-divider |
| frac_val | output | 24 | Fractional multiplier value |
| pwr_down | output | 1 | PLL power-down |
| int_mode | output | 1 | Integer mode select (fractional modulator off) |
| lock_out | output | 1 | Synchronized lock status |

## Verification
The hardest case to reach from the ports is a write whose mask covers only part of a field, or only bits that hold no field. In either case the stored value must keep every bit outside the mask. The stimulus table therefore chains writes to the same word with narrow, empty and unimplemented-bit masks, and each write starts from the value the previous one left. A second hard case is the lock bit. It can only be observed at the exact edges after the raw input changes, so directed steps toggle the input on a falling edge and sample word 2 after each of the next two rising edges. A write of zero to bit 31 is issued while the lock is high.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int ADDR_W  = 4;

    typedef enum logic [1:0] {
        W_FBDIV = 2'd0,
        W_DIVS  = 2'd1,
        W_FRAC  = 2'd2,
        W_CTRL  = 2'd3
    } word_sel_e;

    // implemented-bit masks and reset values of the masked words
    localparam logic [HALF_W-1:0] FBDIV_IMPL = 16'h0FFF;
    localparam logic [HALF_W-1:0] FBDIV_RST  = 16'h0001;
    localparam logic [HALF_W-1:0] DIVS_IMPL  = 16'h773F;
    localparam logic [HALF_W-1:0] DIVS_RST   = 16'h1101;
    localparam logic [HALF_W-1:0] CTRL_IMPL  = 16'h0009;
    localparam logic [HALF_W-1:0] CTRL_RST   = 16'h0009;
endpackage

// File: rtl/pllcfg_masked_reg.sv
module pllcfg_masked_reg #(
    parameter int HW = 16,
    parameter logic [HW-1:0] IMPL = '1,
    parameter logic [HW-1:0] RST  = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2*HW-1:0] wdata,
    output logic [HW-1:0]   q
);
    logic [HW-1:0] bit_en;
    assign bit_en = wdata[2*HW-1:HW] & IMPL;

    for (genvar i = 0; i < HW; i++) begin : g_bit
        if (IMPL[i]) begin : g_store
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q[i] <= RST[i];
                else if (wr_en && bit_en[i])
                    q[i] <= wdata[i];
            end
        end else begin : g_tie
            assign q[i] = 1'b0;
        end
    end

    // R2: bits whose mask bit was clear keep their value across a write
    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((q ^ $past(q)) & ~$past(wdata[2*HW-1:HW])) == '0));

    // R2: no write, no change
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/pllcfg_lock_sync.sv
module pllcfg_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                chain[s] <= 1'b0;
            else if (s == 0)
                chain[s] <= async_in;
            else
                chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pllcfg_regs.sv
module pllcfg_regs
    import pllcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FRAC_W      = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              pll_lock_in,
    output logic [11:0]       fb_div,
    output logic [5:0]        ref_div,
    output logic [2:0]        post_div1,
    output logic [2:0]        post_div2,
    output logic [FRAC_W-1:0] frac_val,
    output logic              pwr_down,
    output logic              int_mode
    ,output logic             lock_out
);
    localparam int FRAC_PAD = WORD_W - 1 - FRAC_W;

    word_sel_e        word;
    logic [HALF_W-1:0] q_fb, q_divs, q_ctrl;
    logic [FRAC_W-1:0] frac_q;

    assign word = word_sel_e'(bus_addr[3:2]);

    pllcfg_masked_reg #(.HW(HALF_W), .IMPL(FBDIV_IMPL), .RST(FBDIV_RST)) u_fb (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && word == W_FBDIV),
        .wdata(bus_wdata), .q(q_fb));

    pllcfg_masked_reg #(.HW(HALF_W), .IMPL(DIVS_IMPL), .RST(DIVS_RST)) u_divs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && word == W_DIVS),
        .wdata(bus_wdata), .q(q_divs));

    pllcfg_masked_reg #(.HW(HALF_W), .IMPL(CTRL_IMPL), .RST(CTRL_RST)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && word == W_CTRL),
        .wdata(bus_wdata), .q(q_ctrl));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            frac_q <= '0;
        else if (bus_wr && word == W_FRAC)
            frac_q <= bus_wdata[FRAC_W-1:0];
    end

    pllcfg_lock_sync #(.STAGES(SYNC_STAGES)) u_lock (
        .clk(clk), .rst_n(rst_n), .async_in(pll_lock_in), .sync_out(lock_out));

    always_comb begin
        unique case (word)
            W_FBDIV: bus_rdata = {{HALF_W{1'b0}}, q_fb};
            W_DIVS:  bus_rdata = {{HALF_W{1'b0}}, q_divs};
            W_FRAC:  bus_rdata = {lock_out, {FRAC_PAD{1'b0}}, frac_q};
            W_CTRL:  bus_rdata = {{HALF_W{1'b0}}, q_ctrl};
            default: bus_rdata = '0;
        endcase
    end

    assign fb_div    = q_fb[11:0];
    assign ref_div   = q_divs[5:0];
    assign post_div1 = q_divs[10:8];
    assign post_div2 = q_divs[14:12];
    assign frac_val  = frac_q;
    assign pwr_down  = q_ctrl[0];
    assign int_mode  = q_ctrl[3];

    // R5: a full-word write loads the fraction unmasked
    p_frac_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[3:2] == 2'd2) |=> frac_val == $past(bus_wdata[FRAC_W-1:0]));

    // R5: writes elsewhere leave the fraction alone
    p_frac_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[3:2] != 2'd2) |=> $stable(frac_val));

    // R7: control output pins only move on a write to the control word
    p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr[3:2] == 2'd3) |=> ($stable(pwr_down) && $stable(int_mode)));
endmodule

// File: tb/pllcfg_regs_test.sv
`timescale 1ns/100ps
module pllcfg_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pll_lock_in = 1'b0;
    logic [11:0] fb_div;
    logic [5:0]  ref_div;
    logic [2:0]  post_div1, post_div2;
    logic [23:0] frac_val;
    logic        pwr_down, int_mode, lock_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pllcfg_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_lock_in(pll_lock_in),
        .fb_div(fb_div), .ref_div(ref_div), .post_div1(post_div1),
        .post_div2(post_div2), .frac_val(frac_val), .pwr_down(pwr_down),
        .int_mode(int_mode), .lock_out(lock_out));

    typedef struct packed {
        logic [7:0]  req;
        logic [3:0]  waddr;
        logic [31:0] wdata;
        logic [3:0]  raddr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{8'd3, 4'h0, 32'hFFFF_0064, 4'h0, 32'h0000_0064}, // R3 full field
        '{8'd2, 4'h0, 32'h0001_0001, 4'h0, 32'h0000_0065}, // R2 one bit
        '{8'd2, 4'h0, 32'h0000_0FFF, 4'h0, 32'h0000_0065}, // R2 empty mask
        '{8'd3, 4'h0, 32'hF000_F000, 4'h0, 32'h0000_0065}, // R3 unimplemented
        '{8'd4, 4'h4, 32'h0700_0300, 4'h4, 32'h0000_1301}, // R4 post1
        '{8'd4, 4'h4, 32'h003F_0002, 4'h4, 32'h0000_1302}, // R4 ref
        '{8'd4, 4'h4, 32'h7000_5000, 4'h4, 32'h0000_5302}, // R4 post2
        '{8'd4, 4'h4, 32'h0800_0800, 4'h4, 32'h0000_5302}, // R4 gap bit
        '{8'd5, 4'h8, 32'hFFAB_CDEF, 4'h8, 32'h00AB_CDEF}, // R5 full word
        '{8'd6, 4'h8, 32'h8000_0000, 4'h8, 32'h0000_0000}, // R6 bit31 ro
        '{8'd7, 4'hC, 32'h0001_0000, 4'hC, 32'h0000_0008}, // R7 power up
        '{8'd7, 4'hC, 32'h0008_0000, 4'hC, 32'h0000_0000}, // R7 frac mode
        '{8'd7, 4'hC, 32'h0006_0006, 4'hC, 32'h0000_0000}, // R7 gap bits
        '{8'd8, 4'h7, 32'h0007_0001, 4'h5, 32'h0000_5301}, // R8 low addr bits
        '{8'd5, 4'h8, 32'h0012_3456, 4'h0, 32'h0000_0065}  // R5 other word
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(input int req, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        read_chk(1, 4'h0, 32'h0000_0001);
        read_chk(1, 4'h4, 32'h0000_1101);
        read_chk(1, 4'h8, 32'h0000_0000);
        read_chk(1, 4'hC, 32'h0000_0009);
        check(1, {20'd0, fb_div}, 32'd1);
        check(1, {pwr_down, int_mode}, 2'b11);

        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i].waddr, VEC[i].wdata);
            read_chk(int'(VEC[i].req), VEC[i].raddr, VEC[i].exp);
        end

        // decoded output ports after the table
        check(3, {20'd0, fb_div}, 32'h65);
        check(4, {26'd0, ref_div}, 32'd1);
        check(4, {29'd0, post_div1}, 32'd3);
        check(4, {29'd0, post_div2}, 32'd5);
        check(5, {8'd0, frac_val}, 32'h12_3456);
        check(7, {pwr_down, int_mode}, 2'b00);

        // R6 lock synchronizer timing
        bus_addr = 4'h8;
        @(negedge clk);
        pll_lock_in = 1'b1;
        @(posedge clk); #1;
        check(6, {31'd0, bus_rdata[31]}, 32'd0);
        @(posedge clk); #1;
        check(6, {31'd0, bus_rdata[31]}, 32'd1);
        check(6, {31'd0, lock_out}, 32'd1);
        bus_write(4'h8, 32'h0000_0042); // bit 31 written as 0
        read_chk(6, 4'h8, 32'h8000_0042);
        pll_lock_in = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check(6, {31'd0, lock_out}, 32'd0);

        // R1 reset mid-run restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        read_chk(1, 4'h4, 32'h0000_1101);
        read_chk(1, 4'hC, 32'h0000_0009);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule